// File: doc/BRIEF.md
# 32-to-16-bit Bus Cycle Translator

This block sits between a 32-bit processor and an older 16-bit peripheral bus. It watches the start strobe, the three cycle-type flags and the four active-low byte enables that the processor drives. From them it builds the signal set of the 16-bit bus: two low address bits, a high-byte enable, a two-bit status code, an address-latch pulse, a data enable, a data direction, and five command strobes. There is one command strobe each for memory read, memory write, I/O read, I/O write and interrupt acknowledge.

A cycle whose enabled bytes lie in both 16-bit halves is split into two 16-bit cycles, low half first. Each translated cycle has a one-clock address phase, followed by a command phase that lasts until the external ready input is sampled low. The processor receives a one-clock acknowledge once the last command has ended. Halt/shutdown cycles and the reserved cycle type issue no command and are acknowledged at once.

Top module: `legacy_bus_xlate`

## Requirements
- R1: Byte-enable bit i belongs to byte lane i. The low half is lanes 0–1 and the high half is lanes 2–3. For the half being transferred, `addr_b1` is 1 for the high half. `addr_b0` is 1 when the half's even lane is disabled and its odd lane is enabled. `hi_byte_en_n` is 0 when the odd lane of the half is enabled. A cycle with no byte enabled runs as a low-half cycle.
- R2: `stat_n` (bit 1, bit 0) is 00 for interrupt acknowledge, 01 for reads, 10 for writes and 11 when idle. It holds the cycle's code from the address phase until the command ends.
- R3: `addr_latch` is high for exactly one clock, in the cycle after a start is sampled (and after the first half of a split). `data_en` is high only while a command strobe is active.
- R4: The flags are `cyc_mem` (1 = memory), `cyc_write` (1 = write) and `cyc_data` (1 = data). A memory cycle asserts only `cmd_mem_rd_n` or `cmd_mem_wr_n`, and an I/O cycle asserts only `cmd_io_rd_n` or `cmd_io_wr_n`, chosen by `cyc_write`. A code fetch (memory, not data, read) counts as a memory read.
- R5: The flag combination mem=0, data=0, write=0 asserts only `cmd_intack_n`.
- R6: A command strobe asserts on the clock after the address-latch pulse and stays asserted until `ext_done_n` is sampled low.
- R7: `data_tx` is 1 for writes and 0 for reads and interrupt acknowledge. It is set during the address phase, before `data_en` rises, and it does not change while `data_en` is high.
- R8: When both halves have enabled bytes, two 16-bit cycles run back to back, low half first, and `proc_ack` comes only after the second one.
- R9: Halt/shutdown (mem=1, data=0, write=1) and the reserved combination (mem=0, data=0, write=1) issue no command and no address-latch pulse. They raise `proc_ack` in the clock after the start is sampled.
- R10: `proc_ack` is high for one clock, in the clock right after the edge that samples `ext_done_n` low on the last command.
- R11: After reset, all command strobes are high, `stat_n` is 11, and `addr_latch`, `data_en`, `data_tx` and `proc_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Processor cycle start, sampled high when idle |
| cyc_mem | input | 1 | 1 = memory cycle, 0 = I/O or acknowledge |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_data | input | 1 | 1 = data cycle, 0 = control cycle |
| byte_en_n | input | 4 | Active-low byte-lane enables |
| ext_done_n | input | 1 | Active-low ready from the 16-bit bus |
| proc_ack | output | 1 | One-clock ready back to the processor |
| addr_b1 | output | 1 | Address bit 1 of the 16-bit cycle |
| addr_b0 | output | 1 | Address bit 0 of the 16-bit cycle |
| hi_byte_en_n | output | 1 | Active-low high-byte enable |
| stat_n | output | 2 | Active-low status code |
| addr_latch | output | 1 | Address latch pulse |
| data_en | output | 1 | Data buffer enable |
| data_tx | output | 1 | Data direction, 1 = transmit |
| cmd_mem_rd_n | output | 1 | Memory read command |
| cmd_mem_wr_n | output | 1 | Memory write command |
| cmd_io_rd_n | output | 1 | I/O read command |
| cmd_io_wr_n | output | 1 | I/O write command |
| cmd_intack_n | output | 1 | Interrupt acknowledge command |

## Verification
The bench builds the block with its default of four upstream byte lanes split into two halves. This covers both the single-half address encodings and the split path. Byte-enable patterns are chosen so that each lane is the lowest enabled lane in at least one cycle, including an all-disabled pattern and a three-lane pattern that splits unevenly. Ready delays of zero, one and two clocks show that the commands hold. Every cycle type is exercised: both memory directions, code fetch, both I/O directions, acknowledge, halt and the reserved type.

// File: rtl/xlb_pkg.sv
package xlb_pkg;

    localparam int unsigned LANES      = 4;
    localparam int unsigned HALF_LANES = LANES / 2;

    // command strobe vector positions
    localparam int unsigned CMD_MRD = 0;
    localparam int unsigned CMD_MWR = 1;
    localparam int unsigned CMD_IRD = 2;
    localparam int unsigned CMD_IWR = 3;
    localparam int unsigned CMD_ACK = 4;
    localparam int unsigned NCMD    = 5;

    typedef enum logic [2:0] {
        K_NONE, K_MEM_RD, K_MEM_WR, K_IO_RD, K_IO_WR, K_INTA
    } kind_t;

    typedef enum logic [1:0] {
        PH_IDLE, PH_ADDR, PH_CMD, PH_ACK
    } phase_t;

    typedef struct packed {
        logic b1;
        logic b0;
        logic hi_en_n;
    } lane_addr_t;

    function automatic kind_t classify(logic mem, logic dat, logic wr);
        case ({mem, dat, wr})
            3'b000:  return K_INTA;
            3'b010:  return K_IO_RD;
            3'b011:  return K_IO_WR;
            3'b100:  return K_MEM_RD;
            3'b110:  return K_MEM_RD;
            3'b111:  return K_MEM_WR;
            default: return K_NONE;
        endcase
    endfunction

    function automatic logic is_write(kind_t k);
        return (k == K_MEM_WR) || (k == K_IO_WR);
    endfunction

    function automatic logic [1:0] status_of(kind_t k);
        case (k)
            K_INTA:            return 2'b00;
            K_MEM_RD, K_IO_RD: return 2'b01;
            K_MEM_WR, K_IO_WR: return 2'b10;
            default:           return 2'b11;
        endcase
    endfunction

    function automatic logic [NCMD-1:0] strobes_of(kind_t k);
        logic [NCMD-1:0] v;
        v = '1;
        case (k)
            K_MEM_RD: v[CMD_MRD] = 1'b0;
            K_MEM_WR: v[CMD_MWR] = 1'b0;
            K_IO_RD:  v[CMD_IRD] = 1'b0;
            K_IO_WR:  v[CMD_IWR] = 1'b0;
            K_INTA:   v[CMD_ACK] = 1'b0;
            default:  v = '1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/xlb_cycle_decode.sv
module xlb_cycle_decode
    import xlb_pkg::*;
#(
    parameter int unsigned NLANE = LANES
) (
    input  logic             mem,
    input  logic             wr,
    input  logic             dat,
    input  logic [NLANE-1:0] be_n,
    output kind_t            kind,
    output logic             need_lo,
    output logic             need_hi
);
    localparam int unsigned H = NLANE / 2;

    logic any_lo, any_hi;

    always_comb begin
        kind    = classify(mem, dat, wr);
        any_lo  = ~&be_n[H-1:0];
        any_hi  = ~&be_n[NLANE-1:H];
        // an empty enable set still runs one low-half cycle (R1)
        need_lo = any_lo | ~any_hi;
        need_hi = any_hi;
    end
endmodule

// File: rtl/xlb_lane_encode.sv
module xlb_lane_encode
    import xlb_pkg::*;
#(
    parameter int unsigned NLANE = LANES
) (
    input  logic [NLANE-1:0] be_n,
    input  logic             sel_hi,
    output lane_addr_t       addr
);
    localparam int unsigned H = NLANE / 2;

    logic [H-1:0] part;

    always_comb begin
        part         = sel_hi ? be_n[NLANE-1:H] : be_n[H-1:0];
        addr.b1      = sel_hi;
        addr.b0      = part[0] & ~part[1];
        addr.hi_en_n = part[1];
    end
endmodule

// File: rtl/xlb_cycle_seq.sv
module xlb_cycle_seq
    import xlb_pkg::*;
#(
    parameter int unsigned NLANE = LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  kind_t            kind_in,
    input  logic [NLANE-1:0] be_in,
    input  logic             need_lo,
    input  logic             need_hi,
    input  logic             done_n,
    output phase_t           phase,
    output logic [NLANE-1:0] be_q,
    output logic             sel_hi,
    output logic             ale,
    output logic             den,
    output logic             dt_tx,
    output logic [1:0]       stat_n,
    output logic [NCMD-1:0]  cmd_n,
    output logic             ack
);
    kind_t kind_q;
    logic  split_q;
    logic  busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            kind_q  <= K_NONE;
            be_q    <= '1;
            sel_hi  <= 1'b0;
            split_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    kind_q  <= kind_in;
                    be_q    <= be_in;
                    sel_hi  <= ~need_lo;
                    split_q <= need_lo & need_hi;
                    phase   <= (kind_in == K_NONE) ? PH_ACK : PH_ADDR;
                end
                PH_ADDR: phase <= PH_CMD;
                PH_CMD: if (!done_n) begin
                    if (split_q && !sel_hi) begin
                        sel_hi <= 1'b1;
                        phase  <= PH_ADDR;
                    end else begin
                        phase  <= PH_ACK;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy   = (phase == PH_ADDR) || (phase == PH_CMD);
        ale    = (phase == PH_ADDR);
        den    = (phase == PH_CMD);
        dt_tx  = busy && is_write(kind_q);
        stat_n = busy ? status_of(kind_q) : 2'b11;
        cmd_n  = den ? strobes_of(kind_q) : '1;
        ack    = (phase == PH_ACK);
    end

    assert_one_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(~cmd_n) <= 1);

    assert_ale_single_R3: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    assert_cmd_after_ale_R6: assert property (@(posedge clk) disable iff (rst)
        (ale && !rst) |=> (~&cmd_n));

    assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (rst)
        ((~&cmd_n) && done_n) |=> (~&cmd_n));

    assert_dir_steady_R7: assert property (@(posedge clk) disable iff (rst)
        (den && (ale || den)) |=> (!den || $stable(dt_tx)));

    assert_stat_hold_R2: assert property (@(posedge clk) disable iff (rst)
        ale |=> $stable(stat_n));

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
endmodule

// File: rtl/legacy_bus_xlate.sv
module legacy_bus_xlate
    import xlb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cyc_start,
    input  logic       cyc_mem,
    input  logic       cyc_write,
    input  logic       cyc_data,
    input  logic [3:0] byte_en_n,
    input  logic       ext_done_n,
    output logic       proc_ack,
    output logic       addr_b1,
    output logic       addr_b0,
    output logic       hi_byte_en_n,
    output logic [1:0] stat_n,
    output logic       addr_latch,
    output logic       data_en,
    output logic       data_tx,
    output logic       cmd_mem_rd_n,
    output logic       cmd_mem_wr_n,
    output logic       cmd_io_rd_n,
    output logic       cmd_io_wr_n,
    output logic       cmd_intack_n
);
    kind_t            kind_d;
    logic             need_lo, need_hi;
    phase_t           phase;
    logic [LANES-1:0] be_q;
    logic             sel_hi;
    logic [NCMD-1:0]  cmd_n;
    lane_addr_t       lane;

    xlb_cycle_decode #(.NLANE(LANES)) u_dec (
        .mem(cyc_mem), .wr(cyc_write), .dat(cyc_data), .be_n(byte_en_n),
        .kind(kind_d), .need_lo(need_lo), .need_hi(need_hi)
    );

    xlb_cycle_seq #(.NLANE(LANES)) u_seq (
        .clk(clk), .rst(rst), .start(cyc_start), .kind_in(kind_d),
        .be_in(byte_en_n), .need_lo(need_lo), .need_hi(need_hi),
        .done_n(ext_done_n), .phase(phase), .be_q(be_q), .sel_hi(sel_hi),
        .ale(addr_latch), .den(data_en), .dt_tx(data_tx), .stat_n(stat_n),
        .cmd_n(cmd_n), .ack(proc_ack)
    );

    xlb_lane_encode #(.NLANE(LANES)) u_lane (
        .be_n(be_q), .sel_hi(sel_hi), .addr(lane)
    );

    always_comb begin
        addr_b1      = lane.b1;
        addr_b0      = lane.b0;
        hi_byte_en_n = lane.hi_en_n;
        cmd_mem_rd_n = cmd_n[CMD_MRD];
        cmd_mem_wr_n = cmd_n[CMD_MWR];
        cmd_io_rd_n  = cmd_n[CMD_IRD];
        cmd_io_wr_n  = cmd_n[CMD_IWR];
        cmd_intack_n = cmd_n[CMD_ACK];
    end

    assert_nocmd_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && cyc_start && kind_d == K_NONE) |=> (proc_ack && !addr_latch));

    assert_den_only_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        data_en |-> (~&cmd_n));
endmodule

// File: tb/sim_legacy_bus_xlate.sv
module sim_legacy_bus_xlate;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_start = 1'b0, cyc_mem = 1'b0, cyc_write = 1'b0, cyc_data = 1'b0;
    logic [3:0] byte_en_n = 4'hF;
    logic ext_done_n = 1'b1;
    logic proc_ack, addr_b1, addr_b0, hi_byte_en_n, addr_latch, data_en, data_tx;
    logic [1:0] stat_n;
    logic cmd_mem_rd_n, cmd_mem_wr_n, cmd_io_rd_n, cmd_io_wr_n, cmd_intack_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    legacy_bus_xlate u0 (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_mem(cyc_mem),
        .cyc_write(cyc_write), .cyc_data(cyc_data), .byte_en_n(byte_en_n),
        .ext_done_n(ext_done_n), .proc_ack(proc_ack), .addr_b1(addr_b1),
        .addr_b0(addr_b0), .hi_byte_en_n(hi_byte_en_n), .stat_n(stat_n),
        .addr_latch(addr_latch), .data_en(data_en), .data_tx(data_tx),
        .cmd_mem_rd_n(cmd_mem_rd_n), .cmd_mem_wr_n(cmd_mem_wr_n),
        .cmd_io_rd_n(cmd_io_rd_n), .cmd_io_wr_n(cmd_io_wr_n),
        .cmd_intack_n(cmd_intack_n)
    );

    typedef struct packed {
        logic       a1;
        logic       a0;
        logic       bhe_n;
        logic [1:0] st;
        logic [4:0] cmd;   // {intack, io_wr, io_rd, mem_wr, mem_rd}, active low
        logic       tx;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   sim_over = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [4:0] cmds_now();
        return {cmd_intack_n, cmd_io_wr_n, cmd_io_rd_n, cmd_mem_wr_n, cmd_mem_rd_n};
    endfunction

    // monitor: compares each address phase and command start with the queue head
    logic prev_cmd = 1'b0;
    always @(negedge clk) begin
        if (!rst && !sim_over) begin
            if (prev_cmd && ext_done_n)
                check(~&cmds_now(), "R6", "command dropped before ready", 16'(cmds_now()), 16'h0);
            if (addr_latch) begin
                if (exp_q.size() == 0) check(1'b0, "R3", "unexpected address phase", 16'h1, 16'h0);
                else begin
                    check({addr_b1, addr_b0, hi_byte_en_n} == {exp_q[0].a1, exp_q[0].a0, exp_q[0].bhe_n},
                          "R1", "lane address", 16'({addr_b1, addr_b0, hi_byte_en_n}),
                          16'({exp_q[0].a1, exp_q[0].a0, exp_q[0].bhe_n}));
                    check(stat_n == exp_q[0].st, "R2", "status at latch", 16'(stat_n), 16'(exp_q[0].st));
                    check(data_tx == exp_q[0].tx && !data_en, "R7", "direction before enable",
                          16'({data_tx, data_en}), 16'({exp_q[0].tx, 1'b0}));
                end
            end
            if ((~&cmds_now()) && !prev_cmd) begin
                if (exp_q.size() == 0) check(1'b0, "R4", "unexpected command", 16'(cmds_now()), 16'h1F);
                else begin
                    check(cmds_now() == exp_q[0].cmd, "R4", "command strobe",
                          16'(cmds_now()), 16'(exp_q[0].cmd));
                    check(data_en && data_tx == exp_q[0].tx && stat_n == exp_q[0].st, "R7",
                          "enable/dir/status in command", 16'({data_en, data_tx, stat_n}),
                          16'({1'b1, exp_q[0].tx, exp_q[0].st}));
                    void'(exp_q.pop_front());
                end
            end
            if (!data_en && (~&cmds_now()))
                check(1'b0, "R3", "command without data enable", 16'(cmds_now()), 16'h1F);
            prev_cmd = ~&cmds_now();
        end
    end

    function automatic exp_t half_exp(input logic [3:0] be, input bit hi,
                                      input logic m, input logic d, input logic w);
        exp_t e;
        logic ev, od;
        ev = !be[hi ? 2 : 0];
        od = !be[hi ? 3 : 1];
        e.a1 = hi;
        e.a0 = !ev && od;
        e.bhe_n = !od;
        e.cmd = 5'h1F;
        if (!m && !d && !w)      begin e.cmd[4] = 1'b0; e.st = 2'b00; end
        else if (!m && d && !w)  begin e.cmd[2] = 1'b0; e.st = 2'b01; end
        else if (!m && d && w)   begin e.cmd[3] = 1'b0; e.st = 2'b10; end
        else if (m && !w)        begin e.cmd[0] = 1'b0; e.st = 2'b01; end
        else                     begin e.cmd[1] = 1'b0; e.st = 2'b10; end
        e.tx = w;
        return e;
    endfunction

    task automatic run_cycle(input logic m, input logic d, input logic w,
                             input logic [3:0] be, input int wt, input string tag);
        bit lo, hi, none, got, lastdone;
        int halves, cnt, ncmd, at;
        none = (!m && !d && w) || (m && !d && w);
        lo = (be[1:0] != 2'b11);
        hi = (be[3:2] != 2'b11);
        if (!lo && !hi) lo = 1'b1;
        halves = none ? 0 : (int'(lo) + int'(hi));
        if (!none) begin
            if (lo) exp_q.push_back(half_exp(be, 1'b0, m, d, w));
            if (hi) exp_q.push_back(half_exp(be, 1'b1, m, d, w));
        end
        @(negedge clk); #1;
        cyc_start = 1'b1; cyc_mem = m; cyc_data = d; cyc_write = w; byte_en_n = be;
        @(negedge clk); #1;
        cyc_start = 1'b0;
        cnt = 0; ncmd = 0; got = 1'b0; lastdone = 1'b0; at = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            if (proc_ack) begin
                got = 1'b1; at = i;
            end else begin
                lastdone = 1'b0;
                if (~&cmds_now()) begin
                    if (cnt == wt) begin
                        ext_done_n = 1'b0; ncmd++; lastdone = 1'b1; cnt = 0;
                    end else begin
                        ext_done_n = 1'b1; cnt++;
                    end
                end else begin
                    ext_done_n = 1'b1; cnt = 0;
                end
                @(negedge clk); #1;
            end
        end
        ext_done_n = 1'b1;
        if (halves == 0)
            check(got && at == 0, "R9", {tag, " immediate ack"}, 16'(at), 16'h0);
        else begin
            check(got && lastdone, "R10", {tag, " ack after last ready"}, 16'(got), 16'h1);
            check(ncmd == halves, "R8", {tag, " commands before ack"}, 16'(ncmd), 16'(halves));
        end
        @(negedge clk); #1;
        check(!proc_ack, "R10", {tag, " ack one clock"}, 16'(proc_ack), 16'h0);
        check(exp_q.size() == 0, "R8", {tag, " all halves seen"}, 16'(exp_q.size()), 16'h0);
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check({cmds_now(), stat_n, addr_latch, data_en, data_tx, proc_ack} == {5'h1F, 2'b11, 4'b0},
              "R11", "reset state", 16'({cmds_now(), stat_n, addr_latch, data_en, data_tx, proc_ack}),
              16'({5'h1F, 2'b11, 4'b0}));
        rst = 1'b0;
        @(negedge clk); #1;
        check(stat_n == 2'b11 && !addr_latch, "R2", "idle after reset", 16'(stat_n), 16'h3);
        run_cycle(1'b1, 1'b1, 1'b0, 4'b0000, 0, "R8 mem read split");
        run_cycle(1'b1, 1'b1, 1'b1, 4'b0001, 2, "R8 mem write uneven split");
        run_cycle(1'b0, 1'b1, 1'b0, 4'b1101, 1, "R4 io read odd lane");
        run_cycle(1'b0, 1'b1, 1'b1, 4'b0111, 0, "R4 io write lane3");
        run_cycle(1'b0, 1'b0, 1'b0, 4'b1110, 1, "R5 intack");
        run_cycle(1'b1, 1'b0, 1'b0, 4'b1011, 0, "R4 code fetch lane2");
        run_cycle(1'b1, 1'b0, 1'b1, 4'b0000, 0, "R9 halt");
        check(exp_q.size() == 0 && !addr_latch, "R9", "halt no latch", 16'(addr_latch), 16'h0);
        run_cycle(1'b0, 1'b0, 1'b1, 4'b1100, 0, "R9 reserved");
        run_cycle(1'b1, 1'b1, 1'b1, 4'b1111, 1, "R1 empty enables");
        run_cycle(1'b1, 1'b1, 1'b0, 4'b1001, 2, "R1 middle lanes split");
        sim_over = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule